// File: doc/BRIEF.md
# Packet Statistics Counter Bank

The block keeps four traffic statistics for one network port: packets sent, packets sent with an error, packets received, and packets received with an error. Each quantity grows by one on every clock cycle in which its event strobe is high. Software reads the statistics through a small read port. The port has an address, a read strobe and a registered data output. The statistics appear as two groups of three words, one group for the transmit direction and one for the receive direction. Each group holds the low half of the packet count, then the high half of the packet count, then the error count.

Reading the low word of a group takes a snapshot of that group. Its three words then stay fixed, so a counter that is wider than one word can be read as one consistent value. A group is reset to zero only when its three words are read in strictly ascending order, starting from the low word. Events that arrive while a group is frozen are not lost. They are held aside and folded in again when the group is released. Reading the words in any other order releases the group and leaves its counts as they were.

Top module: `pkt_stat_bank`

## Requirements
- R1: After reset every counter is zero, rd_data is zero, and all six words read back as zero.
- R2: A read issued with rd_en high in one cycle shows its word on rd_data from the next clock edge. The words sit at offsets from BASE_ADDR as follows: 0 transmit packets low, 1 transmit packets high, 2 transmit errors, 3 receive packets low, 4 receive packets high, 5 receive errors. An address outside those six returns zero. While rd_en is low, rd_data keeps its value.
- R3: Each cycle with tx_pkt, tx_err, rx_pkt or rx_err high adds exactly one to the matching counter, and the four strobes are independent of one another.
- R4: A read of the low word of a group (offset 0 or 3) freezes that group. Until the group is released, the other two words of the group return the values the group held when the low word was read, whatever events arrive in the meantime.
- R5: Reading offsets 0, 1, 2 in that order (or 3, 4, 5) clears the group. Events that arrived after the low-word read are then added to the cleared counters, so the next snapshot returns exactly those events.
- R6: While a group is frozen, a read of its high word or error word out of order releases the group without clearing it. Later reads then return every event counted so far.
- R7: A read of the low word while its group is already frozen takes a new snapshot that includes the events held back so far. That freeze can no longer clear the group. A read order of 0,1,0,1,2 therefore leaves the counts intact.
- R8: The error counters, REG_W bits wide, stop at all ones instead of wrapping.
- R9: The packet counters, 2*REG_W bits wide, wrap to zero past all ones.
- R10: Reads of one group never change the freeze state, the read sequence or the counts of the other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_pkt | input | 1 | One transmitted packet this cycle |
| tx_err | input | 1 | One transmitted error packet this cycle |
| rx_pkt | input | 1 | One received packet this cycle |
| rx_err | input | 1 | One received error packet this cycle |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | REG_W | Registered read data |

## Verification
The bench builds the bank with REG_W set to 8. This makes the packet counters 16 bits wide and the error counters 8 bits wide. With these widths the error counter reaches its saturation point after a few hundred strobes, and the packet counter wraps after about 65,000 cycles, so both limits lie inside a short run. The high word is also non-zero after only a few hundred packets. This lets the snapshot test show that the high word stays at its frozen value while new events arrive. The read orders used are the plain clearing order, an out-of-order break, the restart order 0,1,0,1,2, and reads that interleave the two groups.

// File: rtl/pkt_stat_pkg.sv
package pkt_stat_pkg;

  localparam int unsigned N_GROUPS = 2;
  localparam int unsigned N_SLOTS  = 3;
  localparam int unsigned N_WORDS  = N_GROUPS * N_SLOTS;

  typedef enum logic [1:0] {
    SLOT_LO  = 2'd0,
    SLOT_HI  = 2'd1,
    SLOT_ERR = 2'd2
  } slot_e;

endpackage

// File: rtl/stat_cell.sv
module stat_cell #(
  parameter int unsigned W   = 16,
  parameter bit          SAT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev,
  input  logic         snap,
  input  logic         frozen,
  input  logic         clear,
  input  logic         drain,
  output logic [W-1:0] view
);

  logic [W-1:0] live;
  logic [W-1:0] pend;
  logic [W-1:0] merged;

  function automatic logic [W-1:0] acc(input logic [W-1:0] a,
                                       input logic [W-1:0] b,
                                       input logic         c);
    logic [W+1:0] s;
    s = {2'b00, a} + {2'b00, b} + {{(W+1){1'b0}}, c};
    if (SAT && (s[W+1:W] != 2'b00)) return '1;
    return s[W-1:0];
  endfunction

  assign merged = acc(live, pend, 1'b0);
  assign view   = (frozen && !snap) ? live : merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      pend <= '0;
    end else if (snap) begin
      live <= merged;
      pend <= {{(W-1){1'b0}}, ev};
    end else if (frozen) begin
      pend <= acc(pend, '0, ev);
      if (clear) live <= '0;
    end else if (drain) begin
      live <= acc(live, pend, ev);
      pend <= '0;
    end else begin
      live <= acc(live, '0, ev);
    end
  end

endmodule

// File: rtl/stat_seq.sv
module stat_seq
  import pkt_stat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hit,
  input  slot_e idx,
  output logic  snap,
  output logic  frozen,
  output logic  clear,
  output logic  release_o,
  output logic  drain
);

  slot_e nxt;
  logic  armed;
  logic  adv;
  logic  finish;
  logic  brk;

  assign snap      = hit && (idx == SLOT_LO);
  assign adv       = hit && frozen && !snap && (idx == nxt);
  assign finish    = adv && (nxt == SLOT_ERR);
  assign brk       = hit && frozen && !snap && (idx != nxt);
  assign clear     = finish && armed;
  assign release_o = finish || brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen <= 1'b0;
      nxt    <= SLOT_HI;
      armed  <= 1'b0;
      drain  <= 1'b0;
    end else begin
      drain <= !snap && release_o;
      if (snap) begin
        frozen <= 1'b1;
        nxt    <= SLOT_HI;
        armed  <= !frozen;
      end else if (release_o) begin
        frozen <= 1'b0;
        armed  <= 1'b0;
      end else if (adv) begin
        nxt <= SLOT_ERR;
      end
    end
  end

endmodule

// File: rtl/stat_group.sv
module stat_group
  import pkt_stat_pkg::*;
#(
  parameter int unsigned PKT_W = 32,
  parameter int unsigned ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_ev,
  input  logic             err_ev,
  input  logic             hit,
  input  slot_e            idx,
  output logic [PKT_W-1:0] pkt_view,
  output logic [ERR_W-1:0] err_view,
  output logic             frozen,
  output logic             clear,
  output logic             release_o,
  output logic             drain
);

  logic snap;

  stat_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .idx       (idx),
    .snap      (snap),
    .frozen    (frozen),
    .clear     (clear),
    .release_o (release_o),
    .drain     (drain)
  );

  stat_cell #(.W(PKT_W), .SAT(1'b0)) u_pkt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (pkt_ev),
    .snap   (snap),
    .frozen (frozen),
    .clear  (clear),
    .drain  (drain),
    .view   (pkt_view)
  );

  stat_cell #(.W(ERR_W), .SAT(1'b1)) u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (err_ev),
    .snap   (snap),
    .frozen (frozen),
    .clear  (clear),
    .drain  (drain),
    .view   (err_view)
  );

endmodule

// File: rtl/pkt_stat_bank.sv
module pkt_stat_bank
  import pkt_stat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned REG_W     = 16,
  parameter int unsigned BASE_ADDR = 'h12B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_pkt,
  input  logic              tx_err,
  input  logic              rx_pkt,
  input  logic              rx_err,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);

  localparam int unsigned PKT_W = 2 * REG_W;
  localparam int unsigned ERR_W = REG_W;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic [N_GROUPS-1:0] pkt_ev;
  logic [N_GROUPS-1:0] err_ev;
  logic [N_GROUPS-1:0] grp_hit;
  logic [N_GROUPS-1:0] grp_frozen;
  logic [N_GROUPS-1:0] grp_clear;
  logic [N_GROUPS-1:0] grp_release;
  logic [N_GROUPS-1:0] grp_drain;
  logic [PKT_W-1:0]    pkt_view [N_GROUPS];
  logic [ERR_W-1:0]    err_view [N_GROUPS];

  logic [ADDR_W-1:0] off;
  logic              in_range;
  logic              sel_g;
  slot_e             sel_i;
  logic [REG_W-1:0]  word;

  assign pkt_ev = {rx_pkt, tx_pkt};
  assign err_ev = {rx_err, tx_err};

  assign off      = rd_addr - BASE;
  assign in_range = (rd_addr >= BASE) && (off < ADDR_W'(N_WORDS));

  always_comb begin
    sel_g = 1'b0;
    sel_i = SLOT_LO;
    case (off[2:0])
      3'd1: sel_i = SLOT_HI;
      3'd2: sel_i = SLOT_ERR;
      3'd3: sel_g = 1'b1;
      3'd4: begin sel_g = 1'b1; sel_i = SLOT_HI;  end
      3'd5: begin sel_g = 1'b1; sel_i = SLOT_ERR; end
      default: ;
    endcase
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign grp_hit[g] = rd_en && in_range && (sel_g == g[0]);

    stat_group #(.PKT_W(PKT_W), .ERR_W(ERR_W)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .pkt_ev    (pkt_ev[g]),
      .err_ev    (err_ev[g]),
      .hit       (grp_hit[g]),
      .idx       (sel_i),
      .pkt_view  (pkt_view[g]),
      .err_view  (err_view[g]),
      .frozen    (grp_frozen[g]),
      .clear     (grp_clear[g]),
      .release_o (grp_release[g]),
      .drain     (grp_drain[g])
    );
  end

  always_comb begin
    case (sel_i)
      SLOT_HI:  word = pkt_view[sel_g][PKT_W-1:REG_W];
      SLOT_ERR: word = err_view[sel_g];
      default:  word = pkt_view[sel_g][REG_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= in_range ? word : '0;
  end

endmodule

// File: rtl/pkt_stat_bank_chk.sv
module pkt_stat_bank_chk #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned REG_W     = 16,
  parameter int unsigned BASE_ADDR = 'h12B
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [REG_W-1:0]  rd_data,
  input logic [1:0]        grp_frozen,
  input logic [1:0]        grp_clear,
  input logic [1:0]        grp_release,
  input logic [1:0]        grp_drain
);

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0] rel;
  logic              above;
  logic [1:0]        in_grp;
  logic [1:0]        at_low;

  assign rel       = rd_addr - BASE;
  assign above     = rd_addr >= BASE;
  assign in_grp[0] = rd_en && above && (rel < ADDR_W'(3));
  assign in_grp[1] = rd_en && above && (rel >= ADDR_W'(3)) && (rel < ADDR_W'(6));
  assign at_low[0] = rd_en && above && (rel == ADDR_W'(0));
  assign at_low[1] = rd_en && above && (rel == ADDR_W'(3));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  assert_outside_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_grp[0] && !in_grp[1]) |=> (rd_data == '0));

  for (genvar g = 0; g < 2; g++) begin : g_chk
    assert_low_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      at_low[g] |=> grp_frozen[g]);

    assert_clear_unfreezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      grp_clear[g] |=> (!grp_frozen[g] && grp_drain[g]));

    assert_release_unfreezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grp_release[g] |=> !grp_frozen[g]);

    assert_other_group_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_grp[g] |=> (grp_frozen[g] == $past(grp_frozen[g])));
  end

endmodule

bind pkt_stat_bank pkt_stat_bank_chk #(
  .ADDR_W    (ADDR_W),
  .REG_W     (REG_W),
  .BASE_ADDR (BASE_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .grp_frozen  (grp_frozen),
  .grp_clear   (grp_clear),
  .grp_release (grp_release),
  .grp_drain   (grp_drain)
);

// File: tb/sim_pkt_stat_bank.sv
module sim_pkt_stat_bank;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int REG_W      = 8;
  localparam int BASE       = 'h12B;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tx_pkt = 1'b0, tx_err = 1'b0, rx_pkt = 1'b0, rx_err = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [REG_W-1:0]  rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  pkt_stat_bank #(.ADDR_W(ADDR_W), .REG_W(REG_W), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_pkt(tx_pkt), .tx_err(tx_err),
    .rx_pkt(rx_pkt), .rx_err(rx_err), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic events(input int tp, input int te, input int rp, input int re);
    int n;
    n = tp;
    if (te > n) n = te;
    if (rp > n) n = rp;
    if (re > n) n = re;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_pkt = (i < tp); tx_err = (i < te); rx_pkt = (i < rp); rx_err = (i < re);
    end
    @(negedge clk);
    tx_pkt = 0; tx_err = 0; rx_pkt = 0; rx_err = 0;
  endtask

  task automatic rd(input int off, input int exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = ADDR_W'(BASE + off);
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, int'(rd_data), exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_data after reset", int'(rd_data), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) rd(k, 0, "R1 word zero after reset");

    // plain counting, in-order clear
    events(5, 3, 7, 2);
    rd(0, 5, "R3 tx pkt low");
    rd(1, 0, "R3 tx pkt high");
    rd(2, 3, "R3 tx err");
    rd(3, 7, "R3 rx pkt low");
    rd(4, 0, "R3 rx pkt high");
    rd(5, 2, "R3 rx err");
    for (int k = 0; k < 6; k++) rd(k, 0, "R5 cleared after in-order read");

    // snapshot holds while events arrive; held events survive the clear
    events(300, 0, 0, 0);
    rd(0, 44, "R4 snapshot low");
    events(10, 4, 0, 0);
    rd(1, 1, "R4 snapshot high");
    rd(2, 0, "R4 snapshot err");
    rd(0, 10, "R5 held pkts after clear");
    rd(1, 0, "R5 held pkts high");
    rd(2, 4, "R5 held errs after clear");

    // out-of-order break: no clear; idle hold of rd_data
    events(6, 0, 0, 0);
    rd(0, 6, "R6 first snapshot");
    events(2, 0, 0, 0);
    rd(2, 0, "R6 out-of-order err read");
    rd(0, 8, "R6 counts kept after break");
    repeat (3) @(negedge clk);
    check("R2 rd_data held while idle", int'(rd_data), 8);
    rd(1, 0, "R6 high");
    rd(2, 0, "R6 err");
    rd(0, 0, "R6 cleared by later in-order read");
    rd(1, 0, "R6 high after clear");
    rd(2, 0, "R6 err after clear");

    // restart order 0,1,0,1,2 leaves counts intact
    events(4, 0, 0, 0);
    rd(0, 4, "R7 first snapshot");
    rd(1, 0, "R7 high");
    events(3, 0, 0, 0);
    rd(0, 7, "R7 restart includes held events");
    rd(1, 0, "R7 high after restart");
    rd(2, 0, "R7 err after restart");
    rd(0, 7, "R7 not cleared by restarted sequence");
    rd(1, 0, "R7 high");
    rd(2, 0, "R7 err");
    rd(0, 0, "R7 later clean sequence clears");
    rd(1, 0, "R7 high");
    rd(2, 0, "R7 err");

    // groups independent
    events(9, 0, 5, 0);
    rd(0, 9, "R10 tx snapshot");
    rd(3, 5, "R10 rx low during tx freeze");
    rd(4, 0, "R10 rx high");
    rd(5, 0, "R10 rx err");
    rd(1, 0, "R10 tx sequence survives rx reads");
    rd(2, 0, "R10 tx err");
    rd(0, 0, "R10 tx cleared");
    rd(3, 0, "R10 rx cleared");
    rd(4, 0, "R10 rx high");
    rd(5, 0, "R10 rx err");
    rd(1, 0, "R10 tx high");
    rd(2, 0, "R10 tx err");

    // outside the window
    rd(6, 0, "R2 address past window");
    rd(-1, 0, "R2 address below window");

    // error saturation
    events(0, 300, 0, 0);
    rd(0, 0, "R8 tx pkt low");
    rd(1, 0, "R8 tx pkt high");
    rd(2, 255, "R8 error saturates");

    // packet wrap
    events(65539, 0, 65539, 0);
    rd(0, 3, "R9 tx wrap low");
    rd(1, 0, "R9 tx wrap high");
    rd(2, 0, "R9 tx err");
    rd(3, 3, "R9 rx wrap low");
    rd(4, 0, "R9 rx wrap high");
    rd(5, 0, "R9 rx err");

    summary();
    $finish;
  end

endmodule